// File: doc/BRIEF.md
# Memory-Mapped I/O Port Register Bank

This block gives a microcontroller byte-wide access to one I/O port through a simple strobe-based read/write bus. It holds an output data register and a direction register, and it reads back the live pin levels. It also reads back the resolved per-pin drive enable, which is the OR of the direction bit and an external enable term that a logic array supplies. The pad driver itself sits outside the block. The block drives the output value and the enable towards it.

Two macrocell banks sit beside the plain registers. The output bank is a row of flip-flops. A logic array normally clocks next-state values into it, and the MCU may also overwrite it through a per-bit protection mask. The input bank captures pin levels under per-bit capture enables and presents them both to the MCU and to the logic array. Every register read is returned on a registered data bus one cycle after the read strobe.

Top module: `port_regs_top`

## Requirements
- R1: A read at offset 0 returns the pin inputs as sampled on the clock edge that accepts the read strobe.
- R2: The output data register at offset 1 is written by the MCU, reads back the written value, and drives `pad_out` bit for bit.
- R3: The direction register at offset 2 is readable and writable. Each bit of `pad_oe` is 1 exactly when the matching direction bit or `pt_oe` bit is 1.
- R4: A read at offset 3 returns the current output macrocell flip-flop values, which also appear on `omc_q`.
- R5: A write at offset 3 loads the written data into each output macrocell whose mask bit is 0. A flip-flop whose mask bit is 1 ignores the write data.
- R6: The mask register at offset 4 is readable and writable. A 1 bit blocks MCU loads into the matching output macrocell.
- R7: A read at offset 6 returns the resolved enable of every pin (1 = driving, 0 = tri-state). Writes to offset 6 change nothing.
- R8: On a clock edge where `imc_le[i]` is 1, input macrocell bit i captures `pin_in[i]`. Otherwise it holds. The bank is read at offset 5 and is presented on `imc_q`.
- R9: Where no unmasked MCU write reaches an output macrocell bit, that bit loads `omc_next[i]` on each edge with `omc_ce[i]` high, and holds otherwise. An MCU write takes priority over this load on unmasked bits.
- R10: A read at offset 7 returns 0. Writes to offsets 0, 5, 6 and 7 modify no register.
- R11: A synchronous active-high reset clears the data, direction, mask and both macrocell banks to 0, and clears `bus_rdata`. With `pt_oe` at 0, all pins then sit in tri-state.
- R12: `bus_rdata` changes only on the edge that accepts a read strobe, and keeps its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | MCU write strobe |
| bus_rd | input | 1 | MCU read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Levels seen on the pins |
| pt_oe | input | 8 | Per-pin enable term from the logic array |
| omc_next | input | 8 | Next-state values for the output macrocells |
| omc_ce | input | 8 | Per-bit load enable for the output macrocells |
| imc_le | input | 8 | Per-bit capture enable for the input macrocells |
| pad_out | output | 8 | Output data towards the pad drivers |
| pad_oe | output | 8 | Resolved per-pin drive enable |
| omc_q | output | 8 | Output macrocell flip-flop values |
| imc_q | output | 8 | Input macrocell values towards the logic array |

## Verification
The properties assume that the MCU never raises `bus_rd` and `bus_wr` in the same cycle. This matters for the mask: a read of the mask could otherwise race a write to it. The properties also assume that strobes arrive only after reset has been released. The bench drives every bus operation as a single one-cycle strobe at the falling edge and clears it before the next one, so the two strobes never overlap. Inputs from the logic array are changed only on falling edges, and the bench holds them at 0 while the vector table runs. The directed tests then change these inputs one at a time, so that each of them has a single, attributable effect.

// File: rtl/port_regs_pkg.sv
package port_regs_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIN  = 3'd0,
    OFS_DOUT = 3'd1,
    OFS_DIR  = 3'd2,
    OFS_OMC  = 3'd3,
    OFS_MASK = 3'd4,
    OFS_IMC  = 3'd5,
    OFS_EN   = 3'd6,
    OFS_NONE = 3'd7
  } ofs_e;

  localparam int NUM_CTL = 3;
endpackage

// File: rtl/port_ctl_regs.sv
module port_ctl_regs
  import port_regs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      mask_q
);
  logic [W-1:0] regs_q [NUM_CTL];

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_reg
    localparam ofs_e SEL = (k == 0) ? OFS_DOUT : (k == 1) ? OFS_DIR : OFS_MASK;
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[k] <= '0;
      end else if (wr_en && (ofs_e'(addr) == SEL)) begin
        regs_q[k] <= wdata;
      end
    end
  end

  assign dout_q = regs_q[0];
  assign dir_q  = regs_q[1];
  assign mask_q = regs_q[2];
endmodule

// File: rtl/port_omc_bank.sv
module port_omc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mcu_ld,
  input  logic [W-1:0] mcu_data,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] ce,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_ff
    logic take_mcu;
    assign take_mcu = mcu_ld && !mask[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else if (take_mcu) begin
        q[i] <= mcu_data[i];
      end else if (ce[i]) begin
        q[i] <= nxt[i];
      end
    end
  end
endmodule

// File: rtl/port_imc_bank.sv
module port_imc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] le,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else if (le[i]) begin
        q[i] <= pins[i];
      end
    end
  end
endmodule

// File: rtl/port_rd_mux.sv
module port_rd_mux
  import port_regs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      dout,
  input  logic [W-1:0]      dir,
  input  logic [W-1:0]      omc,
  input  logic [W-1:0]      mask,
  input  logic [W-1:0]      imc,
  input  logic [W-1:0]      en,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] sel_d;

  always_comb begin
    unique case (ofs_e'(addr))
      OFS_DIN:  sel_d = din;
      OFS_DOUT: sel_d = dout;
      OFS_DIR:  sel_d = dir;
      OFS_OMC:  sel_d = omc;
      OFS_MASK: sel_d = mask;
      OFS_IMC:  sel_d = imc;
      OFS_EN:   sel_d = en;
      default:  sel_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= sel_d;
    end
  end
endmodule

// File: rtl/port_regs_top.sv
module port_regs_top
  import port_regs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      pt_oe,
  input  logic [W-1:0]      omc_next,
  input  logic [W-1:0]      omc_ce,
  input  logic [W-1:0]      imc_le,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      omc_q,
  output logic [W-1:0]      imc_q
);
  logic [W-1:0] dout_r;
  logic [W-1:0] dir_r;
  logic [W-1:0] mask_r;
  logic         omc_wr;

  assign omc_wr = bus_wr && (ofs_e'(bus_addr) == OFS_OMC);

  port_ctl_regs #(.W(W)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dout_q(dout_r), .dir_q(dir_r), .mask_q(mask_r)
  );

  port_omc_bank #(.W(W)) u_omc (
    .clk(clk), .rst(rst), .mcu_ld(omc_wr), .mcu_data(bus_wdata), .mask(mask_r),
    .nxt(omc_next), .ce(omc_ce), .q(omc_q)
  );

  port_imc_bank #(.W(W)) u_imc (
    .clk(clk), .rst(rst), .pins(pin_in), .le(imc_le), .q(imc_q)
  );

  assign pad_out = dout_r;
  assign pad_oe  = dir_r | pt_oe;

  port_rd_mux #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr),
    .din(pin_in), .dout(dout_r), .dir(dir_r), .omc(omc_q), .mask(mask_r),
    .imc(imc_q), .en(pad_oe), .rdata(bus_rdata)
  );
endmodule

// File: rtl/port_regs_chk.sv
module port_regs_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pt_oe,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] omc_ce,
  input logic [W-1:0] imc_le,
  input logic [W-1:0] omc_q,
  input logic [W-1:0] imc_q,
  input logic [W-1:0] mask
);
  // R1
  din_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd0) |=> (bus_rdata == $past(pin_in)));

  // R3
  oe_cover_chk: assert property (@(posedge clk) disable iff (rst)
    ((pt_oe & ~pad_oe) == '0));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd2) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

  // R5
  omc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3) |=> ((omc_q & ~$past(mask)) == ($past(bus_wdata) & ~$past(mask))));

  // R6
  omc_block_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3) |=> (((omc_q ^ $past(omc_q)) & $past(mask) & ~$past(omc_ce)) == '0));

  // R8
  imc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((imc_q ^ $past(imc_q)) & ~$past(imc_le)) == '0));

  // R10
  undef_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd7) |=> (bus_rdata == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind port_regs_top port_regs_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pt_oe(pt_oe),
  .pad_oe(pad_oe), .omc_ce(omc_ce), .imc_le(imc_le), .omc_q(omc_q), .imc_q(imc_q),
  .mask(mask_r)
);

// File: tb/port_regs_top_tb.sv
module port_regs_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {wr, rd, addr[2:0], wdata[7:0], expected rdata[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd1, 8'h5A, 8'h00},  // R2 write data out
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h5A},  // R2 read back
    {1'b1, 1'b0, 3'd2, 8'h0F, 8'h00},  // R3 write direction
    {1'b0, 1'b1, 3'd2, 8'h00, 8'h0F},  // R3 read back
    {1'b0, 1'b1, 3'd6, 8'h00, 8'h0F},  // R7 enable readback
    {1'b1, 1'b0, 3'd4, 8'hF0, 8'h00},  // R6 write mask
    {1'b0, 1'b1, 3'd4, 8'h00, 8'hF0},  // R6 read back
    {1'b1, 1'b0, 3'd3, 8'hFF, 8'h00},  // R5 masked load
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h0F},  // R4/R5 read macrocells
    {1'b1, 1'b0, 3'd6, 8'h33, 8'h00},  // R7 write ignored
    {1'b0, 1'b1, 3'd6, 8'h00, 8'h0F},  // R7 unchanged
    {1'b0, 1'b1, 3'd0, 8'h00, 8'hA5},  // R1 pin read
    {1'b0, 1'b1, 3'd7, 8'h00, 8'h00},  // R10 undefined offset
    {1'b1, 1'b0, 3'd0, 8'hFF, 8'h00},  // R10 write to read-only
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h5A}   // R10 data out untouched
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] pin_in = 8'hA5, pt_oe = '0, omc_next = '0, omc_ce = '0, imc_le = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, omc_q, imc_q;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_regs_top u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pt_oe(pt_oe),
    .omc_next(omc_next), .omc_ce(omc_ce), .imc_le(imc_le), .pad_out(pad_out),
    .pad_oe(pad_oe), .omc_q(omc_q), .imc_q(imc_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 rdata", bus_rdata, 8'h00);
    check("R11 pad_oe", pad_oe, 8'h00);
    check("R11 omc_q", omc_q, 8'h00);
    check("R11 imc_q", imc_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      if (VEC[i][19]) check($sformatf("vector %0d", i), bus_rdata, VEC[i][7:0]);
    end

    // R2 / R3 pad side
    pt_oe = 8'hC0;
    #1;
    check("R2 pad_out", pad_out, 8'h5A);
    check("R3 pad_oe", pad_oe, 8'hCF);
    bus_op(1'b0, 1'b1, 3'd6, 8'h00);
    check("R7 enable with pt_oe", bus_rdata, 8'hCF);

    // R12 rdata holds without strobe
    pin_in = 8'h11;
    @(negedge clk);
    check("R12 hold", bus_rdata, 8'hCF);

    // R1 live pins at read edge
    pin_in = 8'h6E;
    bus_op(1'b0, 1'b1, 3'd0, 8'h00);
    check("R1 live pins", bus_rdata, 8'h6E);

    // R8 input macrocells
    pin_in = 8'h3C; imc_le = 8'h0F;
    @(negedge clk);
    imc_le = 8'h00; pin_in = 8'hFF;
    @(negedge clk);
    check("R8 imc_q", imc_q, 8'h0C);
    bus_op(1'b0, 1'b1, 3'd5, 8'h00);
    check("R8 read imc", bus_rdata, 8'h0C);

    // R9 logic-array load, mask F0, omc now 0F
    omc_next = 8'hAA; omc_ce = 8'hFF;
    @(negedge clk);
    check("R9 ce load", omc_q, 8'hAA);
    omc_next = 8'h00;
    bus_op(1'b1, 1'b0, 3'd3, 8'h55);
    check("R9 write priority", omc_q, 8'h05);
    omc_ce = 8'h00; omc_next = 8'hFF;
    @(negedge clk);
    check("R9 hold without ce", omc_q, 8'h05);

    // R6 clear mask, full load
    bus_op(1'b1, 1'b0, 3'd4, 8'h00);
    bus_op(1'b1, 1'b0, 3'd3, 8'hC3);
    bus_op(1'b0, 1'b1, 3'd3, 8'h00);
    check("R6 unmasked load", bus_rdata, 8'hC3);

    // R11 reset again
    bus_op(1'b1, 1'b0, 3'd2, 8'hFF);
    pt_oe = 8'h00;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 re-reset pad_oe", pad_oe, 8'h00);
    check("R11 re-reset pad_out", pad_out, 8'h00);
    bus_op(1'b0, 1'b1, 3'd4, 8'h00);
    check("R11 mask cleared", bus_rdata, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule